// File: doc/BRIEF.md
# Cascaded Maximum-Extraction Sorter

This block sorts a batch of ten 8-bit values that arrive one per clock on a valid/data input. It is built as a chain of stages. Every stage keeps the largest value that has reached it so far and hands each smaller value on to the stage after it. The first stage therefore ends up holding the maximum of the whole batch, and the second stage holds the maximum of the nine values left over. Each later stage resolves one value fewer, down to the last stage, which receives a single value.

A batch begins with a start pulse while the block is idle. The start pulse empties every stage. Values are then accepted on cycles where the input valid is high. After the tenth value has rippled through the chain, a one-cycle done flag is raised. In that same cycle a selector begins to stream the stage contents out, one per clock and smallest first, with an output valid high for exactly ten cycles. The block then returns to idle and waits for the next start.

Top module: `maxcascade_sorter`

## Requirements
- R1: After reset, out_valid_o and done_o are low, and they stay low until a batch has been loaded.
- R2: A start_i pulse while idle empties every stage and opens a new batch. A start_i pulse while a batch is loading, settling or being emitted has no effect on that batch's output.
- R3: While a batch is loading, exactly ten values are taken: one on each clock edge where in_valid_i is high. Cycles with in_valid_i low are skipped and do not end the batch.
- R4: A stage that is empty captures the first value it receives and passes nothing on.
- R5: An occupied stage compares each arriving value with the value it holds. If the arriving value is strictly greater, the stage keeps it and passes the old value on. Otherwise the held value stays unchanged and the arriving value is passed on, which includes the case where the two are equal.
- R6: done_o is high for exactly one cycle. That cycle begins nine clock edges after the edge that captures the tenth value.
- R7: out_valid_o is high for exactly ten consecutive cycles, starting in the done_o cycle. out_data_o carries the batch in non-decreasing order, smallest first, with duplicates repeated.
- R8: in_valid_i outside the loading phase is ignored. Values offered while idle or while results stream out do not change any result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Opens a new batch when idle |
| in_valid_i | input | 1 | Input value present |
| in_data_i | input | 8 | Input value |
| done_o | output | 1 | One-cycle pulse when the sorted batch has settled |
| out_valid_o | output | 1 | Sorted value present on out_data_o |
| out_data_o | output | 8 | Sorted value, ascending |

## Verification
The hardest situation to reach from the ports is the tie case inside a stage, where an arriving value equals the held one and must be passed on while the held value stays put. Only the output order can show that tie-break, and only indirectly. The stimulus reaches it with batches full of repeats, including an all-equal batch and batches mixing the extremes 0 and 255. It also spreads the inputs with idle gaps so that forwarded values from different inputs overlap at different depths of the chain. One batch carries a stray start pulse inside a gap, and another offers junk inputs while results stream out. In both cases the stream is expected to match the sorted batch exactly.

// File: rtl/maxsort_pkg.sv
package maxsort_pkg;
    typedef enum logic [1:0] {
        PH_IDLE,
        PH_LOAD,
        PH_DRAIN,
        PH_EMIT
    } phase_t;
endpackage

// File: rtl/maxsort_stage.sv
module maxsort_stage #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clear_i,
    input  logic         in_vld_i,
    input  logic [W-1:0] in_dat_i,
    output logic         occ_o,
    output logic [W-1:0] held_o,
    output logic         fwd_vld_o,
    output logic [W-1:0] fwd_dat_o
);
    typedef struct packed {
        logic         occ;
        logic [W-1:0] held;
        logic         fv;
        logic [W-1:0] fd;
    } stage_t;

    stage_t st_d, st_q;

    always_comb begin
        st_d    = st_q;
        st_d.fv = 1'b0;
        if (clear_i) begin
            st_d.occ = 1'b0;
        end else if (in_vld_i) begin
            if (!st_q.occ) begin
                st_d.occ  = 1'b1;
                st_d.held = in_dat_i;
            end else if (in_dat_i > st_q.held) begin
                st_d.held = in_dat_i;
                st_d.fv   = 1'b1;
                st_d.fd   = st_q.held;
            end else begin
                st_d.fv   = 1'b1;
                st_d.fd   = in_dat_i;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign occ_o     = st_q.occ;
    assign held_o    = st_q.held;
    assign fwd_vld_o = st_q.fv;
    assign fwd_dat_o = st_q.fd;

    // R4: empty stage captures and forwards nothing
    assert_first_capture_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (in_vld_i && !clear_i && !occ_o) |=>
            (occ_o && !fwd_vld_o && held_o == $past(in_dat_i)));

    // R5: larger arrival replaces held value, old one moves on
    assert_keep_larger_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (in_vld_i && !clear_i && occ_o && in_dat_i > held_o) |=>
            (held_o == $past(in_dat_i) && fwd_vld_o && fwd_dat_o == $past(held_o)));

    // R5: smaller or equal arrival is passed on, held value stable
    assert_pass_smaller_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (in_vld_i && !clear_i && occ_o && in_dat_i <= held_o) |=>
            ($stable(held_o) && fwd_vld_o && fwd_dat_o == $past(in_dat_i)));

    // R2: clear empties the stage
    assert_clear_empties_R2: assert property (@(posedge clk) disable iff (!rst_n)
        clear_i |=> (!occ_o && !fwd_vld_o));
endmodule

// File: rtl/maxsort_ctrl.sv
module maxsort_ctrl
    import maxsort_pkg::*;
#(
    parameter int N = 10
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 start_i,
    input  logic                 in_valid_i,
    output logic                 load_vld_o,
    output logic                 clear_o,
    output logic                 done_o,
    output logic                 emit_o,
    output logic [$clog2(N)-1:0] emit_idx_o
);
    localparam int CW = $clog2(N + 1);
    localparam int IW = $clog2(N);

    typedef struct packed {
        phase_t        ph;
        logic [CW-1:0] cnt;
        logic [IW-1:0] idx;
        logic          done;
    } ctrl_t;

    ctrl_t c_d, c_q;

    always_comb begin
        c_d      = c_q;
        c_d.done = 1'b0;
        case (c_q.ph)
            PH_IDLE: begin
                if (start_i) begin
                    c_d.ph  = PH_LOAD;
                    c_d.cnt = '0;
                end
            end
            PH_LOAD: begin
                if (in_valid_i) begin
                    if (c_q.cnt == CW'(N - 1)) begin
                        c_d.ph  = PH_DRAIN;
                        c_d.cnt = '0;
                    end else begin
                        c_d.cnt = c_q.cnt + 1'b1;
                    end
                end
            end
            PH_DRAIN: begin
                if (c_q.cnt == CW'(N - 2)) begin
                    c_d.ph   = PH_EMIT;
                    c_d.idx  = IW'(N - 1);
                    c_d.done = 1'b1;
                end else begin
                    c_d.cnt = c_q.cnt + 1'b1;
                end
            end
            PH_EMIT: begin
                if (c_q.idx == '0) c_d.ph  = PH_IDLE;
                else               c_d.idx = c_q.idx - 1'b1;
            end
            default: c_d.ph = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) c_q <= '{ph: PH_IDLE, cnt: '0, idx: '0, done: 1'b0};
        else        c_q <= c_d;
    end

    assign load_vld_o = (c_q.ph == PH_LOAD) && in_valid_i;
    assign clear_o    = (c_q.ph == PH_IDLE) && start_i;
    assign done_o     = c_q.done;
    assign emit_o     = (c_q.ph == PH_EMIT);
    assign emit_idx_o = c_q.idx;

    // R3: never more than N values counted in a batch
    assert_count_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (c_q.ph == PH_LOAD) |-> (c_q.cnt < CW'(N)));

    // R6: done is a single-cycle pulse at the first emit cycle
    assert_done_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);
    assert_done_with_emit_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(emit_o) |-> done_o);

    // R7: emit index walks downward one per cycle
    assert_idx_walk_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (emit_o && emit_idx_o != '0) |=> (emit_o && emit_idx_o == $past(emit_idx_o) - 1'b1));
endmodule

// File: rtl/maxsort_select.sv
module maxsort_select #(
    parameter int N = 10,
    parameter int W = 8
) (
    input  logic [W-1:0]         vals_i [N],
    input  logic [$clog2(N)-1:0] idx_i,
    output logic [W-1:0]         val_o
);
    always_comb begin
        val_o = '0;
        for (int k = 0; k < N; k++) begin
            if (idx_i == $clog2(N)'(k)) val_o = vals_i[k];
        end
    end
endmodule

// File: rtl/maxcascade_sorter.sv
module maxcascade_sorter #(
    parameter int N = 10,
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start_i,
    input  logic         in_valid_i,
    input  logic [W-1:0] in_data_i,
    output logic         done_o,
    output logic         out_valid_o,
    output logic [W-1:0] out_data_o
);
    localparam int IW = $clog2(N);

    logic          load_vld, clear_all, emit;
    logic [IW-1:0] emit_idx;
    logic          fwd_v [N+1];
    logic [W-1:0]  fwd_d [N+1];
    logic [W-1:0]  held  [N];
    logic [N-1:0]  occ;

    maxsort_ctrl #(.N(N)) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_i    (start_i),
        .in_valid_i (in_valid_i),
        .load_vld_o (load_vld),
        .clear_o    (clear_all),
        .done_o     (done_o),
        .emit_o     (emit),
        .emit_idx_o (emit_idx)
    );

    assign fwd_v[0] = load_vld;
    assign fwd_d[0] = in_data_i;

    for (genvar s = 0; s < N; s++) begin : g_stage
        maxsort_stage #(.W(W)) u_stage (
            .clk       (clk),
            .rst_n     (rst_n),
            .clear_i   (clear_all),
            .in_vld_i  (fwd_v[s]),
            .in_dat_i  (fwd_d[s]),
            .occ_o     (occ[s]),
            .held_o    (held[s]),
            .fwd_vld_o (fwd_v[s+1]),
            .fwd_dat_o (fwd_d[s+1])
        );
    end

    maxsort_select #(.N(N), .W(W)) u_sel (
        .vals_i (held),
        .idx_i  (emit_idx),
        .val_o  (out_data_o)
    );

    assign out_valid_o = emit;

    // R3: the last stage receives a single value and never forwards
    assert_last_quiet_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!fwd_v[N] && fwd_d[N] == '0));

    // R7: every stage is filled while results stream out
    assert_all_filled_R7: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid_o |-> (&occ));

    // R7: stream is non-decreasing
    assert_ascending_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid_o && $past(out_valid_o)) |-> (out_data_o >= $past(out_data_o)));

    // R1: nothing emitted without a done pulse opening the stream
    assert_no_stray_out_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(out_valid_o) |-> done_o);
endmodule

// File: tb/maxcascade_sorter_bench.sv
module maxcascade_sorter_bench;
    localparam int N = 10;
    localparam int W = 8;
    localparam time CLK_PERIOD = 10ns;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         start_i = 1'b0;
    logic         in_valid_i = 1'b0;
    logic [W-1:0] in_data_i = '0;
    logic         done_o, out_valid_o;
    logic [W-1:0] out_data_o;

    maxcascade_sorter #(.N(N), .W(W)) u_maxcascade_sorter (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .in_valid_i(in_valid_i),
        .in_data_i(in_data_i), .done_o(done_o), .out_valid_o(out_valid_o),
        .out_data_o(out_data_o)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    int checks = 0;
    int fails = 0;
    int cyc = 0;
    int last_accept = -1;
    int run_len = 0;
    bit finished = 1'b0;
    logic [W-1:0] exp_q [$];

    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d (cycle %0d)", req, act, exp, cyc);
        end
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    endtask

    // monitor: scoreboard pop and timing checks
    always @(negedge clk) begin
        if (rst_n) begin
            if (out_valid_o) begin
                run_len++;
                if (exp_q.size() == 0) begin
                    check(1'b0, "R7 unexpected output", int'(out_data_o), -1);
                end else begin
                    logic [W-1:0] e;
                    e = exp_q.pop_front();
                    check(out_data_o == e, "R7 sorted value", int'(out_data_o), int'(e));
                end
            end else if (run_len != 0) begin
                check(run_len == N, "R7 stream length", run_len, N);
                run_len = 0;
            end
            if (done_o) begin
                check(cyc == last_accept + N - 1, "R6 done timing", cyc, last_accept + N - 1);
                check(out_valid_o, "R7 stream starts with done", int'(out_valid_o), 1);
            end
        end
    end

    task automatic run_batch(input logic [W-1:0] v [N], input int gap_every,
                             input bit stray_start, input bit noise);
        logic [W-1:0] s [N];
        bit stray_done = 1'b0;
        s = v;
        for (int i = 0; i < N; i++)
            for (int j = 0; j < N - 1 - i; j++)
                if (s[j] > s[j+1]) begin
                    logic [W-1:0] t;
                    t = s[j]; s[j] = s[j+1]; s[j+1] = t;
                end
        for (int i = 0; i < N; i++) exp_q.push_back(s[i]);

        @(negedge clk); start_i = 1'b1;
        @(negedge clk); start_i = 1'b0;
        for (int i = 0; i < N; i++) begin
            if (gap_every > 0 && i > 0 && (i % gap_every) == 0) begin
                in_valid_i = 1'b0;
                in_data_i  = 8'hFF;
                if (stray_start && !stray_done) begin
                    start_i = 1'b1;   // R2: ignored mid-load
                    stray_done = 1'b1;
                end
                @(negedge clk);
                start_i = 1'b0;
            end
            in_valid_i  = 1'b1;
            in_data_i   = v[i];
            last_accept = cyc + 1;
            @(negedge clk);
        end
        in_valid_i = 1'b0;
        while (!done_o) @(negedge clk);
        if (noise) begin
            for (int i = 0; i < N; i++) begin
                in_valid_i = 1'b1;     // R8: ignored while emitting
                in_data_i  = W'(i * 3);
                start_i    = (i == 4); // R2: ignored while emitting
                @(negedge clk);
            end
            in_valid_i = 1'b0;
            start_i    = 1'b0;
        end
        while (out_valid_o) @(negedge clk);
        @(negedge clk);
        check(exp_q.size() == 0, "R7 all values emitted", exp_q.size(), 0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        check(1'b0, "watchdog", cyc, 0);
        summary();
    end

    initial begin
        logic [W-1:0] v [N];
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(!out_valid_o, "R1 reset out_valid", int'(out_valid_o), 0);
        check(!done_o, "R1 reset done", int'(done_o), 0);

        // R8: inputs while idle without start are ignored
        for (int i = 0; i < 5; i++) begin
            in_valid_i = 1'b1; in_data_i = W'(200 + i);
            @(negedge clk);
            check(!out_valid_o && !done_o, "R8 idle input ignored", int'(out_valid_o), 0);
        end
        in_valid_i = 1'b0;

        // R5: mixed values
        for (int i = 0; i < N; i++) v[i] = W'(i * 37 + 11);
        run_batch(v, 0, 1'b0, 1'b0);

        // R3: descending arrival with idle gaps
        for (int i = 0; i < N; i++) v[i] = W'(250 - i * 20);
        run_batch(v, 3, 1'b0, 1'b0);

        // R5: duplicates and extremes, R2 stray start inside a gap
        v = '{8'd255, 8'd0, 8'd7, 8'd255, 8'd7, 8'd0, 8'd128, 8'd7, 8'd1, 8'd254};
        run_batch(v, 2, 1'b1, 1'b0);

        // R5: all equal
        for (int i = 0; i < N; i++) v[i] = 8'd42;
        run_batch(v, 0, 1'b0, 1'b0);

        // R8: noise during output, ascending arrival
        for (int i = 0; i < N; i++) v[i] = W'(i * 5);
        run_batch(v, 4, 1'b0, 1'b1);

        // R1: idle again afterwards
        repeat (3) @(negedge clk);
        check(!out_valid_o, "R1 idle after batches", int'(out_valid_o), 0);
        summary();
    end
endmodule